// File: doc/BRIEF.md
# Transmit Pad Stripper

This block sits on the transmit path of a 64-bit packet stream. Every outgoing packet arrives with six filler bytes in front of it. Those bytes were added earlier so that the network headers land on aligned boundaries inside the chip. The block removes the filler before the packet reaches the framing logic, so that the first output word begins with the destination address.

Because six bytes come off the front, every remaining byte moves six lanes toward the start of the stream. Each output word is therefore built from the last two bytes of one input word and the first six bytes of the next. The byte count of the final word is worked out again from the shifted length. A packet whose final input word holds seven or eight bytes needs one tail word of its own. A packet whose final word holds six bytes or fewer comes out one word shorter than it went in.

On the output, bit 3 of the user sideband marks the first word of each packet. On the input, the same bit carries an error flag, and the block does not look at it. Both sides use a valid/ready handshake, and stalls on either side are absorbed without losing or repeating data.

Top module: `tx_pad_strip`

## Requirements
- R1: The output byte sequence of each packet equals its input bytes from index 6 onward. Byte k of a word sits at tdata[63-8k -: 8], so byte 0 is in the most significant lane.
- R2: Output tuser[3] is 1 on the first output word of each packet and 0 on every other output word.
- R3: Input tuser[3] has no effect on any output.
- R4: tuser[2:0] gives the number of valid bytes in a last word, with 0 meaning all 8. On output words that are not last it is 0.
- R5: When the last input word holds 1 to 6 bytes, the output packet has one word fewer than the input, and its last word holds that count plus 2 bytes.
- R6: When the last input word holds 7 or 8 bytes, the output packet has the same number of words as the input, and its last word holds 1 or 2 bytes.
- R7: While m_tvalid is high and m_tready is low, the output word, sideband and tlast stay unchanged. No byte is lost or duplicated under stalls on either side.
- R8: A packet of 6 bytes or fewer (one input word with occupancy 1 to 6) is accepted and produces no output.
- R9: After reset, m_tvalid is low and s_tready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 64 | Input packet data, byte 0 in bits 63:56 |
| s_tuser | input | 4 | [2:0] last-word occupancy, [3] error flag (ignored) |
| s_tlast | input | 1 | Last word of the input packet |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block accepts the input word |
| m_tdata | output | 64 | Output data with the pad removed |
| m_tuser | output | 4 | [2:0] last-word occupancy, [3] start of packet |
| m_tlast | output | 1 | Last word of the output packet |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream accepts the output word |

## Verification
The bench drives packets of every length from 1 to 70 bytes, so every last-word occupancy occurs. This separates the case that merges the tail into the previous word (1 to 6 bytes) from the case that adds a tail word (7 or 8 bytes). Packets of 6 bytes or fewer are placed between long ones to show that they vanish without shifting their neighbours. Runs with no stalls, packed back to back, are set against runs with random gaps on the input and random stalls on the output. A mismatch only under stalls points to the handshake rather than to the lane shift. Some packets carry the error flag on every word, and their output must match the same packet sent without the flag.

// File: rtl/pad_strip_pkg.sv
package pad_strip_pkg;

    localparam int DATA_W  = 64;
    localparam int LANES   = DATA_W / 8;
    localparam int OCC_W   = $clog2(LANES);
    localparam int USER_W  = OCC_W + 1;
    localparam int SOF_BIT = OCC_W;
    localparam int CNT_W   = $clog2(LANES + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [OCC_W-1:0]  occ;
        logic              sof;
        logic              last;
    } beat_t;

    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_BODY  = 2'd1,
        ST_TAIL  = 2'd2
    } state_t;

    // occupancy field to byte count (0 encodes a full word)
    function automatic cnt_t occ_to_cnt(input logic [OCC_W-1:0] occ);
        return (occ == '0) ? cnt_t'(LANES) : cnt_t'(occ);
    endfunction

    // byte count 1..LANES to occupancy field; LANES wraps to 0
    function automatic logic [OCC_W-1:0] cnt_to_occ(input cnt_t c);
        return c[OCC_W-1:0];
    endfunction

endpackage

// File: rtl/pad_strip_align.sv
module pad_strip_align
    import pad_strip_pkg::*;
#(
    parameter int KEEP_W = 16
)(
    input  logic [KEEP_W-1:0] hold,
    input  logic [DATA_W-1:0] word,
    input  logic              use_word,
    output logic [DATA_W-1:0] merged
);
    localparam int FILL_W = DATA_W - KEEP_W;

    generate
        if (FILL_W > 0) begin : g_merge
            logic [FILL_W-1:0] fill;
            assign fill   = use_word ? word[DATA_W-1:KEEP_W] : '0;
            assign merged = {hold, fill};
        end else begin : g_pass
            assign merged = hold;
        end
    endgenerate

endmodule

// File: rtl/pad_strip_ctrl.sv
module pad_strip_ctrl
    import pad_strip_pkg::*;
#(
    parameter int PAD_BYTES = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic [OCC_W-1:0]  s_occ,
    input  logic              s_last,
    output logic              s_ready,
    output logic              e_valid,
    output beat_t             e_beat,
    input  logic              e_ready
);
    localparam int KEEP   = LANES - PAD_BYTES;
    localparam int KEEP_W = KEEP * 8;

    state_t            st_q, st_d;
    logic [KEEP_W-1:0] hold_q, hold_d;
    logic              sof_q, sof_d;
    cnt_t              tail_q, tail_d;
    cnt_t              in_cnt;
    logic              short_last;
    logic [DATA_W-1:0] merged;

    pad_strip_align #(.KEEP_W(KEEP_W)) u_align (
        .hold     (hold_q),
        .word     (s_data),
        .use_word (st_q == ST_BODY),
        .merged   (merged)
    );

    always_comb begin
        in_cnt     = occ_to_cnt(s_occ);
        short_last = s_last && (in_cnt <= cnt_t'(PAD_BYTES));
        st_d       = st_q;
        hold_d     = hold_q;
        sof_d      = sof_q;
        tail_d     = tail_q;
        s_ready    = 1'b0;
        e_valid    = 1'b0;
        e_beat     = '0;
        e_beat.data = merged;
        e_beat.sof  = sof_q;
        case (st_q)
            ST_FIRST: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    hold_d = s_data[KEEP_W-1:0];
                    sof_d  = 1'b1;
                    tail_d = cnt_t'(in_cnt - cnt_t'(PAD_BYTES));
                    if (!s_last)
                        st_d = ST_BODY;
                    else if (!short_last)
                        st_d = ST_TAIL;
                end
            end
            ST_BODY: begin
                s_ready     = e_ready;
                e_valid     = s_valid;
                e_beat.last = short_last;
                e_beat.occ  = short_last ? cnt_to_occ(cnt_t'(in_cnt + cnt_t'(KEEP))) : '0;
                if (s_valid && e_ready) begin
                    hold_d = s_data[KEEP_W-1:0];
                    sof_d  = 1'b0;
                    tail_d = cnt_t'(in_cnt - cnt_t'(PAD_BYTES));
                    if (s_last)
                        st_d = short_last ? ST_FIRST : ST_TAIL;
                end
            end
            ST_TAIL: begin
                e_valid     = 1'b1;
                e_beat.last = 1'b1;
                e_beat.occ  = cnt_to_occ(tail_q);
                if (e_ready) begin
                    st_d  = ST_FIRST;
                    sof_d = 1'b0;
                end
            end
            default: st_d = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_FIRST;
            hold_q <= '0;
            sof_q  <= 1'b0;
            tail_q <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            sof_q  <= sof_d;
            tail_q <= tail_d;
        end
    end

    // R7
    tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAIL && !e_ready) |=> (st_q == ST_TAIL && $stable(hold_q)));

endmodule

// File: rtl/pad_strip_oreg.sv
module pad_strip_oreg
    import pad_strip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  i_valid,
    input  beat_t i_beat,
    output logic  i_ready,
    output logic  o_valid,
    output beat_t o_beat,
    input  logic  o_ready
);
    logic  v_q;
    beat_t b_q;

    assign i_ready = !v_q || o_ready;
    assign o_valid = v_q;
    assign o_beat  = b_q;

    always_ff @(posedge clk) begin
        if (rst)
            v_q <= 1'b0;
        else if (i_ready)
            v_q <= i_valid;
    end

    always_ff @(posedge clk) begin
        if (rst)
            b_q <= '0;
        else if (i_valid && i_ready)
            b_q <= i_beat;
    end

    // R7
    stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (v_q && !o_ready) |=> (v_q && $stable(b_q)));

endmodule

// File: rtl/tx_pad_strip.sv
module tx_pad_strip
    import pad_strip_pkg::*;
#(
    parameter int PAD_BYTES = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [USER_W-1:0] s_tuser,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    logic  e_valid, e_ready;
    beat_t e_beat, o_beat;
    logic  err_unused;

    // input error flag deliberately dropped
    assign err_unused = s_tuser[SOF_BIT];

    pad_strip_ctrl #(.PAD_BYTES(PAD_BYTES)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .s_valid (s_tvalid),
        .s_data  (s_tdata),
        .s_occ   (s_tuser[OCC_W-1:0]),
        .s_last  (s_tlast),
        .s_ready (s_tready),
        .e_valid (e_valid),
        .e_beat  (e_beat),
        .e_ready (e_ready)
    );

    pad_strip_oreg u_oreg (
        .clk     (clk),
        .rst     (rst),
        .i_valid (e_valid),
        .i_beat  (e_beat),
        .i_ready (e_ready),
        .o_valid (m_tvalid),
        .o_beat  (o_beat),
        .o_ready (m_tready)
    );

    assign m_tdata = o_beat.data;
    assign m_tuser = {o_beat.sof, o_beat.occ};
    assign m_tlast = o_beat.last;

    // ---------------- protocol checks ----------------
    logic       out_mid_q, in_first_q;
    logic [7:0] pend_q;
    logic       in_fire, out_fire, long_end;

    assign in_fire  = s_tvalid && s_tready;
    assign out_fire = m_tvalid && m_tready;
    assign long_end = in_fire && s_tlast &&
                      !(in_first_q && occ_to_cnt(s_tuser[OCC_W-1:0]) <= cnt_t'(PAD_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mid_q  <= 1'b0;
            in_first_q <= 1'b1;
            pend_q     <= '0;
        end else begin
            if (out_fire) out_mid_q <= !m_tlast;
            if (in_fire)  in_first_q <= s_tlast;
            pend_q <= pend_q + 8'(long_end) - 8'(out_fire && m_tlast);
        end
    end

    // R2
    sof_first_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !out_mid_q) |-> m_tuser[SOF_BIT]);

    // R2
    sof_later_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && out_mid_q) |-> !m_tuser[SOF_BIT]);

    // R8
    no_phantom_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fire && m_tlast) |-> (pend_q != 8'd0));

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!m_tvalid && s_tready));

endmodule

// File: tb/tb_tx_pad_strip.sv
module tb_tx_pad_strip;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] s_tdata = '0;
    logic [3:0]  s_tuser = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [3:0]  m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    tx_pad_strip dut (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int   n_vec = 0;
    int   n_bad = 0;
    bit   rdy_full = 1'b1;
    bit   finished = 1'b0;
    int   pkts_expected = 0;
    int   pkts_seen = 0;

    int   exp_len[$];
    bit   exp_err[$];
    byte unsigned exp_bytes[$];

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // expected output for a packet: its bytes from index 6 on
    function automatic int out_len(int len);
        return (len >= 7) ? len - 6 : 0;
    endfunction

    task automatic send_pkt(int len, bit err, bit gaps);
        byte unsigned pk[$];
        int nw;
        for (int i = 0; i < len; i++) pk.push_back(8'($urandom));
        if (out_len(len) > 0) begin
            exp_len.push_back(out_len(len));
            exp_err.push_back(err);
            for (int i = 6; i < len; i++) exp_bytes.push_back(pk[i]);
            pkts_expected++;
        end
        nw = (len + 7) / 8;
        for (int w = 0; w < nw; w++) begin
            logic [63:0] d;
            int cnt;
            d = {$urandom, $urandom};
            cnt = (w == nw - 1) ? len - 8 * w : 8;
            for (int j = 0; j < cnt; j++) d[63 - 8 * j -: 8] = pk[8 * w + j];
            @(negedge clk);
            while (gaps && $urandom_range(0, 3) == 0) begin
                s_tvalid = 1'b0;
                @(negedge clk);
            end
            s_tvalid = 1'b1;
            s_tdata  = d;
            s_tlast  = (w == nw - 1);
            s_tuser  = {err | (($urandom_range(0, 1) == 1) && err), 3'(cnt % 8)};
            if (w != nw - 1) s_tuser[2:0] = 3'($urandom);
            #1;
            while (!s_tready) begin
                @(negedge clk);
                #1;
            end
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        s_tvalid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rdy_full) m_tready = ($urandom_range(0, 3) != 0);
        else m_tready = 1'b1;
    end

    // output monitor
    bit          rx_active = 1'b0;
    int          rx_len = 0;
    int          rx_pos = 0;
    bit          rx_err = 1'b0;
    bit          stall_prev = 1'b0;
    logic [63:0] pd;
    logic [3:0]  pu;
    logic        pl;

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (stall_prev)
                chk(m_tvalid && m_tdata == pd && m_tuser == pu && m_tlast == pl,
                    "R7", "stalled word changed", {pu, m_tdata[59:0]}, {m_tuser, pd[59:0]});
            stall_prev = m_tvalid && !m_tready;
            pd = m_tdata; pu = m_tuser; pl = m_tlast;
            if (m_tvalid && m_tready) begin
                int rem, n;
                bit exp_last;
                if (!rx_active) begin
                    if (exp_len.size() == 0) begin
                        chk(0, "R8", "unexpected output packet", 1, 0);
                        rx_len = 8; rx_err = 0;
                    end else begin
                        rx_len = exp_len.pop_front();
                        rx_err = exp_err.pop_front();
                    end
                    rx_pos = 0;
                    rx_active = 1'b1;
                    pkts_seen++;
                    chk(m_tuser[3] == 1'b1, "R2", "sof on first word", 64'(m_tuser[3]), 1);
                end else begin
                    chk(m_tuser[3] == 1'b0, "R2", "sof on later word", 64'(m_tuser[3]), 0);
                end
                rem = rx_len - rx_pos;
                exp_last = (rem <= 8);
                chk(m_tlast == exp_last, ((rx_len + 6) % 8 inside {7, 0}) ? "R6" : "R5",
                    "tlast position", 64'(m_tlast), 64'(exp_last));
                chk(m_tuser[2:0] == (exp_last ? 3'(rem % 8) : 3'd0), "R4", "occupancy",
                    64'(m_tuser[2:0]), 64'(exp_last ? rem % 8 : 0));
                n = (rem < 8) ? rem : 8;
                for (int j = 0; j < n; j++) begin
                    byte unsigned eb;
                    eb = (exp_bytes.size() > 0) ? exp_bytes.pop_front() : 8'h00;
                    chk(m_tdata[63 - 8 * j -: 8] == eb, rx_err ? "R3" : "R1", "data byte",
                        64'(m_tdata[63 - 8 * j -: 8]), 64'(eb));
                end
                rx_pos += n;
                if (m_tlast) begin
                    while (rx_pos < rx_len && exp_bytes.size() > 0) begin
                        void'(exp_bytes.pop_front());
                        rx_pos++;
                    end
                    rx_active = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin
        void'($urandom(32'h5A17_0C3D));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R9
        chk(m_tvalid == 1'b0, "R9", "m_tvalid after reset", 64'(m_tvalid), 0);
        chk(s_tready == 1'b1, "R9", "s_tready after reset", 64'(s_tready), 1);

        // directed: each tail case, back to back, no stalls (R5, R6)
        rdy_full = 1'b1;
        for (int len = 7; len <= 24; len++) send_pkt(len, 1'b0, 1'b0);
        // R8: short packets between long ones
        for (int len = 1; len <= 6; len++) begin
            send_pkt(len, 1'b0, 1'b0);
            send_pkt(10 + len, 1'b0, 1'b0);
        end
        // R3: error flag set on every word
        send_pkt(29, 1'b1, 1'b0);
        send_pkt(15, 1'b1, 1'b0);
        send_pkt(8, 1'b1, 1'b0);
        idle(10);
        // R8: nothing left over after short packets
        chk(exp_len.size() == 0 && !rx_active, "R8", "directed packets drained",
            64'(exp_len.size()), 0);

        // random phase with stalls both sides (R7)
        rdy_full = 1'b0;
        for (int p = 0; p < 400; p++)
            send_pkt($urandom_range(1, 70), $urandom_range(0, 3) == 0, 1'b1);
        idle(1);
        rdy_full = 1'b1;
        while (exp_len.size() != 0 || rx_active) @(negedge clk);
        idle(10);
        chk(pkts_seen == pkts_expected, "R8", "output packet count",
            64'(pkts_seen), 64'(pkts_expected));
        chk(exp_bytes.size() == 0, "R1", "leftover expected bytes", 64'(exp_bytes.size()), 0);
        wrap_up();
    end

endmodule